// File: doc/BRIEF.md
# Sectored Instruction Cache with Wrapping Burst Fill

This block is a direct-mapped instruction cache for a 32-bit fetch unit. It has 16 lines of four longwords each, 256 bytes in all. Each line keeps a single base-address tag. Each longword in the line has its own valid bit, so a line may be only partly filled. On a miss the cache asks external memory for one longword. When the burst configuration input is set, it asks instead for a four-beat burst. The burst starts at the requested longword and wraps within the line. The fetch unit receives the requested longword in the cycle its beat arrives.

A hit is answered in the same cycle as the request, with no memory activity. Memory flags each returned beat with an inhibit bit. An inhibited beat is passed to the fetch unit but never stored. A one-cycle invalidate input empties the whole cache. If that invalidate lands while a fill is in progress, nothing more from that fill is kept.

A practical consequence of the shared line tag: a code loop almost as large as the cache stays resident only if it starts on a line boundary. Shifted by part of a line, it spills into a seventeenth line whose index is already used by its own first line.

Top module: `icache_sector`

## Requirements
- R1: Addresses are longword addresses (byte address bits 31..2). Bits 1..0 of `cpu_lwaddr` select the longword in the line, bits 5..2 select the line, and `cpu_fc` together with bits 29..6 form the tag. A request whose tag matches and whose longword is valid gets `cpu_ack` in the same cycle with the stored data, and no memory request is made.
- R2: A miss with `burst_en` low raises `mem_req` with `mem_burst` low and `mem_lwaddr` equal to the requested longword address. It takes exactly one beat. That beat's data is returned on `cpu_rdata`. Only that longword of the line becomes valid.
- R3: A miss on a line whose tag matches fills only the missing longword. The line's other valid longwords stay valid.
- R4: A miss on a line holding a different tag re-tags the line. Every other longword of the line becomes invalid.
- R5: A miss with `burst_en` high raises `mem_req` with `mem_burst` high and takes four beats. Memory returns the requested longword first and then the following ones, wrapping within the line. All four longwords become valid with the correct data.
- R6: The requested longword is acknowledged to the fetch unit in the cycle its beat arrives (the first beat), not at the end of the burst.
- R7: A beat returned with `mem_inhibit` high is delivered to the fetch unit but not stored. A later request for that longword misses again.
- R8: A one-cycle pulse on `inval_all` makes every longword of every line invalid.
- R9: If `inval_all` is high in any cycle of a fill, neither the beat of that cycle nor any later beat of the same fill is stored.
- R10: In single-longword mode, a block of 62 consecutive longwords that starts on a 16-byte boundary runs a second pass with no misses. The same block started 12 bytes past a boundary misses twice on every pass after the first.
- R11: During and after reset, every longword is invalid, `mem_req` is low and no request is acknowledged without a fill.
- R12: The function-code bit is part of the tag. The same address with a different `cpu_fc` misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Fetch request, held until acknowledged |
| cpu_lwaddr | input | 30 | Longword address of the fetch |
| cpu_fc | input | 1 | Function-code bit, part of the tag |
| cpu_ack | output | 1 | Fetch data valid this cycle |
| cpu_rdata | output | 32 | Fetched longword |
| burst_en | input | 1 | Fill a whole line on a miss (sampled when the miss starts) |
| inval_all | input | 1 | Clear all valid bits |
| mem_req | output | 1 | External read in progress |
| mem_lwaddr | output | 30 | Longword address of the first beat |
| mem_burst | output | 1 | Four-beat wrapping read when high, single beat when low |
| mem_ack | input | 1 | A beat is present on `mem_rdata` |
| mem_rdata | input | 32 | Beat data |
| mem_inhibit | input | 1 | Do not store this beat |

## Verification
Two functions of this block can fall in the same cycle: the whole-cache invalidate and the storing of a fill beat. The bench starts a burst and watches for the beat that forwards the requested longword. It then raises `inval_all` for exactly the cycle in which the second beat arrives. The result is judged at the ports. The forwarded data must be correct, and afterwards all four longwords of that line must each cost a new memory transaction, counted from `mem_req`. That shows neither the colliding beat nor the later beats survived.

// File: rtl/icache_sector_pkg.sv
package icache_sector_pkg;

   // Fill sequencer states
   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_FILL = 1'b1
   } fill_state_e;

endpackage

// File: rtl/ics_tag_store.sv
module ics_tag_store #(
   parameter int LINES = 16,
   parameter int WORDS = 4,
   parameter int TAG_W = 25
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inval_all,
   input  logic                     wr_en,
   input  logic [$clog2(LINES)-1:0] wr_idx,
   input  logic [$clog2(WORDS)-1:0] wr_word,
   input  logic [TAG_W-1:0]         wr_tag,
   input  logic [$clog2(LINES)-1:0] rd_idx,
   output logic [TAG_W-1:0]         rd_tag,
   output logic [WORDS-1:0]         rd_vld
);
   localparam int IDX_W = $clog2(LINES);

   logic [TAG_W-1:0] tag_all [LINES];
   logic [WORDS-1:0] vld_all [LINES];
   logic [WORDS-1:0] word_1h;

   assign word_1h = WORDS'(1) << wr_word;

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [TAG_W-1:0] tag_r;
      logic [WORDS-1:0] vld_r;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(l));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_r <= '0;
            vld_r <= '0;
         end else if (inval_all) begin
            vld_r <= '0;
         end else if (sel) begin
            if (tag_r == wr_tag) begin
               vld_r <= vld_r | word_1h;
            end else begin
               tag_r <= wr_tag;
               vld_r <= word_1h;
            end
         end
      end

      assign tag_all[l] = tag_r;
      assign vld_all[l] = vld_r;
   end

   assign rd_tag = tag_all[rd_idx];
   assign rd_vld = vld_all[rd_idx];

   // ---------------- checks ----------------
   logic             any_vld;
   logic [TAG_W-1:0] wr_line_tag;
   logic [WORDS-1:0] wr_line_vld;
   logic [IDX_W-1:0] chk_idx_q;

   always_comb begin
      any_vld = 1'b0;
      for (int l = 0; l < LINES; l++) any_vld = any_vld | (|vld_all[l]);
   end

   assign wr_line_tag = tag_all[wr_idx];
   assign wr_line_vld = vld_all[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_idx_q <= '0;
      else        chk_idx_q <= wr_idx;
   end

   assert_inval_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      inval_all |=> !any_vld);

   assert_retag_drops_others_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !inval_all && wr_line_tag != wr_tag)
      |=> (vld_all[chk_idx_q] == $past(word_1h)));

   assert_same_tag_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !inval_all && wr_line_tag == wr_tag)
      |=> (vld_all[chk_idx_q] == ($past(wr_line_vld) | $past(word_1h))));

endmodule

// File: rtl/ics_data_store.sv
module ics_data_store #(
   parameter int LINES  = 16,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(LINES)-1:0] wr_idx,
   input  logic [$clog2(WORDS)-1:0] wr_word,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [$clog2(LINES)-1:0] rd_idx,
   input  logic [$clog2(WORDS)-1:0] rd_word,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int ENTRIES = LINES * WORDS;
   localparam int PTR_W   = $clog2(ENTRIES);

   logic [DATA_W-1:0] mem_q [ENTRIES];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;

   assign wr_ptr = {wr_idx, wr_word};
   assign rd_ptr = {rd_idx, rd_word};

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_ptr] <= wr_data;
   end

   assign rd_data = mem_q[rd_ptr];

endmodule

// File: rtl/ics_fill_ctrl.sv
module ics_fill_ctrl
   import icache_sector_pkg::*;
#(
   parameter int LW_W  = 30,
   parameter int WORDS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cpu_req,
   input  logic [LW_W-1:0]          cpu_lwaddr,
   input  logic                     cpu_fc,
   input  logic                     lookup_hit,
   input  logic                     burst_en,
   input  logic                     inval_all,
   input  logic                     mem_ack,
   input  logic                     mem_inhibit,
   output logic                     mem_req,
   output logic [LW_W-1:0]          mem_lwaddr,
   output logic                     mem_burst,
   output logic                     idle,
   output logic                     fwd_valid,
   output logic                     wr_en,
   output logic [$clog2(WORDS)-1:0] wr_word,
   output logic [LW_W-1:0]          fill_lwaddr,
   output logic                     fill_fc
);
   localparam int WSEL_W = $clog2(WORDS);

   fill_state_e       state_q;
   logic [LW_W-1:0]   addr_q;
   logic              fc_q;
   logic              burst_q;
   logic              drop_q;
   logic [WSEL_W-1:0] beat_q;
   logic              start;
   logic              last_beat;

   assign start     = (state_q == FS_IDLE) && cpu_req && !lookup_hit;
   assign last_beat = burst_q ? (beat_q == WSEL_W'(WORDS - 1)) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         addr_q  <= '0;
         fc_q    <= 1'b0;
         burst_q <= 1'b0;
         drop_q  <= 1'b0;
         beat_q  <= '0;
      end else begin
         case (state_q)
            FS_IDLE: begin
               if (start) begin
                  state_q <= FS_FILL;
                  addr_q  <= cpu_lwaddr;
                  fc_q    <= cpu_fc;
                  burst_q <= burst_en;
                  drop_q  <= 1'b0;
                  beat_q  <= '0;
               end
            end
            FS_FILL: begin
               if (inval_all) drop_q <= 1'b1;
               if (mem_ack) begin
                  beat_q <= beat_q + 1'b1;
                  if (last_beat) state_q <= FS_IDLE;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign idle        = (state_q == FS_IDLE);
   assign mem_req     = (state_q == FS_FILL);
   assign mem_lwaddr  = addr_q;
   assign mem_burst   = burst_q;
   assign fwd_valid   = mem_req && mem_ack && (beat_q == '0);
   assign wr_en       = mem_req && mem_ack && !mem_inhibit && !inval_all && !drop_q;
   assign wr_word     = addr_q[WSEL_W-1:0] + beat_q;
   assign fill_lwaddr = addr_q;
   assign fill_fc     = fc_q;

   // ---------------- checks ----------------
   logic fwd_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fwd_seen_q <= 1'b0;
      else if (start)     fwd_seen_q <= 1'b0;
      else if (fwd_valid) fwd_seen_q <= 1'b1;
   end

   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_lwaddr) && $stable(mem_burst)));

   assert_single_one_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_burst && mem_ack) |=> !mem_req);

   assert_one_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> !fwd_seen_q);

   assert_no_store_after_inval_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && inval_all) |=> !wr_en);

endmodule

// File: rtl/icache_sector.sv
module icache_sector #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 16,
   parameter int WORDS  = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cpu_req,
   input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]    cpu_lwaddr,
   input  logic                                  cpu_fc,
   output logic                                  cpu_ack,
   output logic [DATA_W-1:0]                     cpu_rdata,
   input  logic                                  burst_en,
   input  logic                                  inval_all,
   output logic                                  mem_req,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    mem_lwaddr,
   output logic                                  mem_burst,
   input  logic                                  mem_ack,
   input  logic [DATA_W-1:0]                     mem_rdata,
   input  logic                                  mem_inhibit
);
   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int LW_W   = ADDR_W - BYTE_W;
   localparam int WSEL_W = $clog2(WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_LO = WSEL_W + IDX_W;
   localparam int TAG_W  = LW_W - TAG_LO + 1;

   // elaboration-time parameter checks
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power of two, at least 8");
   end
   if (LW_W <= TAG_LO) begin : g_bad_addr
      $error("ADDR_W too narrow for the cache geometry");
   end

   logic [IDX_W-1:0]  rd_idx;
   logic [WSEL_W-1:0] rd_word;
   logic [TAG_W-1:0]  rd_tag_cmp;
   logic [TAG_W-1:0]  line_tag;
   logic [WORDS-1:0]  line_vld;
   logic [DATA_W-1:0] hit_data;
   logic              lookup_hit;

   logic              fill_idle;
   logic              fwd_valid;
   logic              fill_wr_en;
   logic [WSEL_W-1:0] fill_word;
   logic [LW_W-1:0]   fill_lwaddr;
   logic              fill_fc;
   logic [IDX_W-1:0]  wr_idx;
   logic [TAG_W-1:0]  wr_tag;

   assign rd_word    = cpu_lwaddr[WSEL_W-1:0];
   assign rd_idx     = cpu_lwaddr[WSEL_W +: IDX_W];
   assign rd_tag_cmp = {cpu_fc, cpu_lwaddr[LW_W-1:TAG_LO]};
   assign lookup_hit = (line_tag == rd_tag_cmp) && line_vld[rd_word];

   assign wr_idx = fill_lwaddr[WSEL_W +: IDX_W];
   assign wr_tag = {fill_fc, fill_lwaddr[LW_W-1:TAG_LO]};

   ics_fill_ctrl #(
      .LW_W  (LW_W),
      .WORDS (WORDS)
   ) u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (cpu_req),
      .cpu_lwaddr  (cpu_lwaddr),
      .cpu_fc      (cpu_fc),
      .lookup_hit  (lookup_hit),
      .burst_en    (burst_en),
      .inval_all   (inval_all),
      .mem_ack     (mem_ack),
      .mem_inhibit (mem_inhibit),
      .mem_req     (mem_req),
      .mem_lwaddr  (mem_lwaddr),
      .mem_burst   (mem_burst),
      .idle        (fill_idle),
      .fwd_valid   (fwd_valid),
      .wr_en       (fill_wr_en),
      .wr_word     (fill_word),
      .fill_lwaddr (fill_lwaddr),
      .fill_fc     (fill_fc)
   );

   ics_tag_store #(
      .LINES (LINES),
      .WORDS (WORDS),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .inval_all (inval_all),
      .wr_en     (fill_wr_en),
      .wr_idx    (wr_idx),
      .wr_word   (fill_word),
      .wr_tag    (wr_tag),
      .rd_idx    (rd_idx),
      .rd_tag    (line_tag),
      .rd_vld    (line_vld)
   );

   ics_data_store #(
      .LINES  (LINES),
      .WORDS  (WORDS),
      .DATA_W (DATA_W)
   ) u_data (
      .clk     (clk),
      .wr_en   (fill_wr_en),
      .wr_idx  (wr_idx),
      .wr_word (fill_word),
      .wr_data (mem_rdata),
      .rd_idx  (rd_idx),
      .rd_word (rd_word),
      .rd_data (hit_data)
   );

   assign cpu_ack   = (fill_idle && cpu_req && lookup_hit) || fwd_valid;
   assign cpu_rdata = fwd_valid ? mem_rdata : hit_data;

   // ---------------- checks ----------------
   assert_hit_no_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ack && !mem_req) |=> !mem_req);

   assert_ack_needs_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |-> !cpu_ack);

endmodule

// File: tb/tb_icache_sector.sv
`timescale 1ns/1ps
module tb_icache_sector;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [29:0] cpu_lwaddr = '0;
   logic        cpu_fc = 1'b0;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        burst_en = 1'b0;
   logic        inval_all = 1'b0;
   logic        mem_req;
   logic [29:0] mem_lwaddr;
   logic        mem_burst;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_inhibit = 1'b0;

   int          checks = 0;
   int          fails = 0;
   int          cyc = 0;
   int          txn_cnt = 0;
   int          first_beat_cyc = -1;
   logic        last_burst = 1'b0;
   logic [31:0] last_addr = '0;
   bit          inh_mode = 1'b0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   icache_sector dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (cpu_req),
      .cpu_lwaddr  (cpu_lwaddr),
      .cpu_fc      (cpu_fc),
      .cpu_ack     (cpu_ack),
      .cpu_rdata   (cpu_rdata),
      .burst_en    (burst_en),
      .inval_all   (inval_all),
      .mem_req     (mem_req),
      .mem_lwaddr  (mem_lwaddr),
      .mem_burst   (mem_burst),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .mem_inhibit (mem_inhibit)
   );

   function automatic logic [31:0] mdata(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'hC3A5_1E0F;
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // external memory: two cycles of latency, then one beat or four wrapping beats
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_req) begin
            logic [31:0] base;
            logic [1:0]  wsel;
            int          nb;
            base = {mem_lwaddr, 2'b00};
            nb   = mem_burst ? 4 : 1;
            txn_cnt++;
            last_burst = mem_burst;
            last_addr  = base;
            repeat (2) @(negedge clk);
            for (int k = 0; k < nb; k++) begin
               wsel        = base[3:2] + 2'(k);
               mem_ack     = 1'b1;
               mem_inhibit = inh_mode;
               mem_rdata   = mdata({base[31:4], wsel, 2'b00});
               if (k == 0) first_beat_cyc = cyc;
               @(negedge clk);
            end
            mem_ack     = 1'b0;
            mem_inhibit = 1'b0;
         end
      end
   end

   task automatic fetch(input logic [31:0] a, input logic fc,
                        output logic [31:0] d, output bit miss, output int ack_c);
      int t0;
      int w;
      @(negedge clk);
      t0         = txn_cnt;
      cpu_req    = 1'b1;
      cpu_lwaddr = a[31:2];
      cpu_fc     = fc;
      #1;
      w = 0;
      while (!cpu_ack && w < 100) begin
         @(negedge clk);
         #1;
         w++;
      end
      if (!cpu_ack) check(1'b0, "R1", "ack timeout", 32'd0, 32'd1);
      d     = cpu_rdata;
      ack_c = cyc;
      miss  = (txn_cnt != t0);
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic expect_fetch(input logic [31:0] a, input logic fc,
                               input bit exp_miss, input string rq);
      logic [31:0] d;
      bit          m;
      int          c;
      fetch(a, fc, d, m, c);
      check(d == mdata(a), rq, "data", d, mdata(a));
      check(m == exp_miss, rq, "miss", 32'(m), 32'(exp_miss));
   endtask

   task automatic pulse_inval();
      @(negedge clk);
      inval_all = 1'b1;
      @(negedge clk);
      inval_all = 1'b0;
   endtask

   task automatic run_block(input logic [31:0] base, input int n, output int misses);
      logic [31:0] d;
      bit          m;
      int          c;
      int          bad;
      misses = 0;
      bad    = 0;
      for (int i = 0; i < n; i++) begin
         fetch(base + 32'(4 * i), 1'b0, d, m, c);
         if (m) misses++;
         if (d != mdata(base + 32'(4 * i))) bad++;
      end
      check(bad == 0, "R10", "bad data count", 32'(bad), 32'd0);
   endtask

   // R11: reset state
   task automatic t_reset();
      cpu_req    = 1'b1;
      cpu_lwaddr = 30'h40;
      repeat (3) @(negedge clk);
      #1;
      check(cpu_ack == 1'b0, "R11", "cpu_ack in reset", 32'(cpu_ack), 32'd0);
      check(mem_req == 1'b0, "R11", "mem_req in reset", 32'(mem_req), 32'd0);
      cpu_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      expect_fetch(32'h0000_0100, 1'b0, 1'b1, "R11");
   endtask

   // R1, R2: single miss then hit
   task automatic t_single();
      burst_en = 1'b0;
      expect_fetch(32'h0000_2008, 1'b0, 1'b1, "R2");
      check(last_burst == 1'b0, "R2", "mem_burst", 32'(last_burst), 32'd0);
      check(last_addr == 32'h0000_2008, "R2", "mem address", last_addr, 32'h0000_2008);
      expect_fetch(32'h0000_2008, 1'b0, 1'b0, "R1");
      expect_fetch(32'h0000_200C, 1'b0, 1'b1, "R2");
   endtask

   // R3: same tag keeps the other longwords
   task automatic t_same_tag();
      expect_fetch(32'h0000_2008, 1'b0, 1'b0, "R3");
      expect_fetch(32'h0000_200C, 1'b0, 1'b0, "R3");
   endtask

   // R4: different tag clears the line
   task automatic t_retag();
      expect_fetch(32'h0000_2108, 1'b0, 1'b1, "R4");
      expect_fetch(32'h0000_200C, 1'b0, 1'b1, "R4");
      expect_fetch(32'h0000_2108, 1'b0, 1'b1, "R4");
   endtask

   // R12: function-code bit in the tag
   task automatic t_fc();
      expect_fetch(32'h0000_3000, 1'b0, 1'b1, "R12");
      expect_fetch(32'h0000_3000, 1'b1, 1'b1, "R12");
      expect_fetch(32'h0000_3000, 1'b1, 1'b0, "R12");
   endtask

   // R5, R6: wrapping burst and early forward
   task automatic t_burst();
      logic [31:0] d;
      bit          m;
      int          c;
      burst_en = 1'b1;
      fetch(32'h0000_4008, 1'b0, d, m, c);
      check(d == mdata(32'h0000_4008), "R5", "burst data", d, mdata(32'h0000_4008));
      check(m == 1'b1, "R5", "burst miss", 32'(m), 32'd1);
      check(last_burst == 1'b1, "R5", "mem_burst", 32'(last_burst), 32'd1);
      check(c == first_beat_cyc, "R6", "ack cycle", 32'(c), 32'(first_beat_cyc));
      expect_fetch(32'h0000_4000, 1'b0, 1'b0, "R5");
      expect_fetch(32'h0000_4004, 1'b0, 1'b0, "R5");
      expect_fetch(32'h0000_400C, 1'b0, 1'b0, "R5");
      burst_en = 1'b0;
   endtask

   // R7: inhibited beat not stored
   task automatic t_inhibit();
      inh_mode = 1'b1;
      expect_fetch(32'h0000_5004, 1'b0, 1'b1, "R7");
      inh_mode = 1'b0;
      expect_fetch(32'h0000_5004, 1'b0, 1'b1, "R7");
      expect_fetch(32'h0000_5004, 1'b0, 1'b0, "R7");
   endtask

   // R8: invalidate everything
   task automatic t_inval();
      expect_fetch(32'h0000_6000, 1'b0, 1'b1, "R8");
      expect_fetch(32'h0000_6010, 1'b0, 1'b1, "R8");
      expect_fetch(32'h0000_6000, 1'b0, 1'b0, "R8");
      pulse_inval();
      expect_fetch(32'h0000_6000, 1'b0, 1'b1, "R8");
      expect_fetch(32'h0000_6010, 1'b0, 1'b1, "R8");
   endtask

   // R9: invalidate in the same cycle as the second burst beat
   task automatic t_inval_mid_fill();
      logic [31:0] d;
      bit          m;
      int          c;
      burst_en = 1'b1;
      fork
         fetch(32'h0000_7004, 1'b0, d, m, c);
         begin
            @(negedge clk);
            #1;
            while (!mem_ack) begin
               @(negedge clk);
               #1;
            end
            @(negedge clk);
            inval_all = 1'b1;
            @(negedge clk);
            inval_all = 1'b0;
         end
      join
      check(d == mdata(32'h0000_7004), "R9", "forwarded data", d, mdata(32'h0000_7004));
      burst_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         expect_fetch(32'h0000_7000 + 32'(4 * i), 1'b0, 1'b1, "R9");
      end
   endtask

   // R10: near-full block, aligned against misaligned
   task automatic t_fit();
      int ms;
      burst_en = 1'b0;
      pulse_inval();
      run_block(32'h0000_8000, 62, ms);
      check(ms == 62, "R10", "aligned pass1 misses", 32'(ms), 32'd62);
      run_block(32'h0000_8000, 62, ms);
      check(ms == 0, "R10", "aligned pass2 misses", 32'(ms), 32'd0);
      pulse_inval();
      run_block(32'h0000_800C, 62, ms);
      check(ms == 62, "R10", "misaligned pass1 misses", 32'(ms), 32'd62);
      run_block(32'h0000_800C, 62, ms);
      check(ms == 2, "R10", "misaligned pass2 misses", 32'(ms), 32'd2);
      run_block(32'h0000_800C, 62, ms);
      check(ms == 2, "R10", "misaligned pass3 misses", 32'(ms), 32'd2);
      pulse_inval();
      burst_en = 1'b1;
      run_block(32'h0000_9000, 62, ms);
      check(ms == 16, "R5", "burst block misses", 32'(ms), 32'd16);
      run_block(32'h0000_9000, 62, ms);
      check(ms == 0, "R10", "burst block pass2 misses", 32'(ms), 32'd0);
      burst_en = 1'b0;
   endtask

   initial begin
      t_reset();
      t_single();
      t_same_tag();
      t_retag();
      t_fc();
      t_burst();
      t_inhibit();
      t_inval();
      t_inval_mid_fill();
      t_fit();
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule